// File: doc/BRIEF.md
# SDRAM Read Burst Output Pipeline

This block models the read side of a pipelined synchronous DRAM as seen from the data pins. A READ command arrives on a clock edge with a bank and a starting column. The block then walks a burst of four column addresses and looks each one up in a small internal word array. Each word is placed on the data bus after a programmable number of clocks, called the CAS latency.

Commands can be issued on any edge. A READ that arrives while an earlier burst is still being walked cuts that burst short, and its own words follow in its own latency slots. Because of this, back-to-back commands give a gap-free stream. A mask input blanks individual output words two clocks after it is sampled, without pausing the burst.

Top module: `sdram_rd_pipe`

## Requirements
- R1: A READ sampled on edge k puts its first word on `dout`, with `doutValid` high, just after edge k+L. L is `casLat` for values 1 to 3, and a `casLat` of 0 acts as 1. `casLat` is changed only while no burst is in flight.
- R2: A READ at column c returns four words on consecutive edges. Their columns are c, then c with its two low bits plus 1, plus 2 and plus 3, taken modulo 4, so the column stays inside its aligned group of four.
- R3: The word at bank b and column c equals {b, c} zero-extended to 32 bits and XORed with 32'hA5A5_0000.
- R4: A READ is accepted on every edge, including one edge after another READ. The new READ ends the older burst: every older word whose output edge is at or after the new first-word edge is replaced by the new burst.
- R5: A READ issued exactly four edges after the previous one gives an unbroken stream. The new first word follows the old fourth word on the next edge, for every latency.
- R6: Any READ may target either bank, including the bank of the previous READ.
- R7: `dqMask` high when sampled on edge j forces `dout` to zero and `doutValid` low just after edge j+2. The burst keeps advancing, so the next unmasked word is the one that would have appeared anyway.
- R8: When no burst word is due, `dout` is zero and `doutValid` is low.
- R9: While `rstN` is low, `dout` is zero and `doutValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| casLat | input | 2 | CAS latency in clocks (1 to 3; 0 acts as 1) |
| cmdRead | input | 1 | READ command strobe |
| cmdBank | input | 1 | Bank selected by the READ |
| cmdCol | input | 8 | Starting column of the READ |
| dqMask | input | 1 | Output mask, acting two edges after sampling |
| dout | output | 32 | Read data bus, zero when idle or masked |
| doutValid | output | 1 | High when `dout` carries a burst word |

## Verification
Two events can land on the same output edge: a burst being cut short by a new READ, and the mask blanking a word. The random phase drives READs at irregular spacings, including every edge, while raising the mask now and then. As a result, a blanked slot often coincides with the handover from an old burst to a new one. The bench keeps the pending words and the pending blanks in separate ring buffers indexed by output edge, so a later READ that rewrites a slot cannot clear a blank that is already due there. Each edge is then compared against the merged expectation.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;

  // Per-cycle strobes handed from the burst control to the datapath.
  typedef struct packed {
    logic load;   // a burst word is due at the output this edge
    logic blank;  // the mask suppresses this edge's word
  } rdStrobe_t;

endpackage

// File: rtl/rd_burst_ctrl.sv
module rd_burst_ctrl
  import sdram_rd_pkg::*;
#(
  parameter int BANK_W    = 1,
  parameter int COL_W     = 8,
  parameter int BURST_LEN = 4,
  parameter int MAX_CL    = 3,
  parameter int MASK_DLY  = 2,
  localparam int CL_W     = $clog2(MAX_CL + 1),
  localparam int BL_W     = $clog2(BURST_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CL_W-1:0]   casLat,
  input  logic              cmdRead,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic [COL_W-1:0]  cmdCol,
  input  logic              dqMask,
  output rdStrobe_t         strobe,
  output logic [BANK_W-1:0] selBank,
  output logic [COL_W-1:0]  selCol
);

  // Latency clamped to 1..MAX_CL.
  logic [CL_W-1:0] effLat;
  always_comb begin
    if (casLat == '0) effLat = CL_W'(1);
    else if (int'(casLat) > MAX_CL) effLat = CL_W'(MAX_CL);
    else effLat = casLat;
  end

  // Burst generator: first stage of the command-to-output pipe.
  logic              genValid;
  logic [BL_W-1:0]   genIdx;
  logic [BANK_W-1:0] genBank;
  logic [COL_W-1:0]  genBase;
  logic [COL_W-1:0]  genCol;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      genValid <= 1'b0;
      genIdx   <= '0;
      genBank  <= '0;
      genBase  <= '0;
    end else if (cmdRead) begin
      genValid <= 1'b1;
      genIdx   <= '0;
      genBank  <= cmdBank;
      genBase  <= cmdCol;
    end else if (genValid) begin
      if (genIdx == BL_W'(BURST_LEN - 1)) genValid <= 1'b0;
      genIdx <= genIdx + 1'b1;
    end
  end

  // Column wraps inside the burst-aligned block.
  assign genCol = {genBase[COL_W-1:BL_W], genBase[BL_W-1:0] + genIdx};

  logic              selValid;

  generate
    if (MAX_CL > 1) begin : g_delay
      localparam int STAGES = MAX_CL - 1;
      logic              dlyValid [STAGES];
      logic [BANK_W-1:0] dlyBank  [STAGES];
      logic [COL_W-1:0]  dlyCol   [STAGES];

      always_ff @(posedge clk) begin
        if (!rstN) begin
          for (int i = 0; i < STAGES; i++) begin
            dlyValid[i] <= 1'b0;
            dlyBank[i]  <= '0;
            dlyCol[i]   <= '0;
          end
        end else begin
          dlyValid[0] <= genValid;
          dlyBank[0]  <= genBank;
          dlyCol[0]   <= genCol;
          for (int i = 1; i < STAGES; i++) begin
            dlyValid[i] <= dlyValid[i-1];
            dlyBank[i]  <= dlyBank[i-1];
            dlyCol[i]   <= dlyCol[i-1];
          end
        end
      end

      always_comb begin
        selValid = genValid;
        selBank  = genBank;
        selCol   = genCol;
        for (int i = 0; i < STAGES; i++) begin
          if (int'(effLat) == i + 2) begin
            selValid = dlyValid[i];
            selBank  = dlyBank[i];
            selCol   = dlyCol[i];
          end
        end
      end
    end else begin : g_direct
      always_comb begin
        selValid = genValid;
        selBank  = genBank;
        selCol   = genCol;
      end
    end
  endgenerate

  // Mask delay line.
  logic [MASK_DLY-1:0] maskPipe;
  always_ff @(posedge clk) begin
    if (!rstN) maskPipe <= '0;
    else if (MASK_DLY == 1) maskPipe <= MASK_DLY'(dqMask);
    else maskPipe <= {maskPipe[MASK_DLY-2:0], dqMask};
  end

  assign strobe.load  = selValid;
  assign strobe.blank = maskPipe[MASK_DLY-1];

endmodule

// File: rtl/rd_data_path.sv
module rd_data_path
  import sdram_rd_pkg::*;
#(
  parameter int BANK_W = 1,
  parameter int COL_W  = 8,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] SALT = DATA_W'(32'hA5A5_0000)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdStrobe_t         strobe,
  input  logic [BANK_W-1:0] selBank,
  input  logic [COL_W-1:0]  selCol,
  output logic [DATA_W-1:0] dout,
  output logic              doutValid
);

  // Word array contents, computed per cell.
  function automatic logic [DATA_W-1:0] cellWord(
    input logic [BANK_W-1:0] bank,
    input logic [COL_W-1:0]  col
  );
    return DATA_W'({bank, col}) ^ SALT;
  endfunction

  logic drive;
  assign drive = strobe.load && !strobe.blank;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dout      <= '0;
      doutValid <= 1'b0;
    end else if (drive) begin
      dout      <= cellWord(selBank, selCol);
      doutValid <= 1'b1;
    end else begin
      dout      <= '0;
      doutValid <= 1'b0;
    end
  end

endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe
  import sdram_rd_pkg::*;
#(
  parameter int BANK_W    = 1,
  parameter int COL_W     = 8,
  parameter int DATA_W    = 32,
  parameter int BURST_LEN = 4,
  parameter int MAX_CL    = 3,
  parameter logic [DATA_W-1:0] SALT = DATA_W'(32'hA5A5_0000),
  localparam int CL_W     = $clog2(MAX_CL + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CL_W-1:0]   casLat,
  input  logic              cmdRead,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic [COL_W-1:0]  cmdCol,
  input  logic              dqMask,
  output logic [DATA_W-1:0] dout,
  output logic              doutValid
);

  rdStrobe_t         strobe;
  logic [BANK_W-1:0] selBank;
  logic [COL_W-1:0]  selCol;

  rd_burst_ctrl #(
    .BANK_W(BANK_W), .COL_W(COL_W), .BURST_LEN(BURST_LEN),
    .MAX_CL(MAX_CL), .MASK_DLY(2)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .casLat(casLat), .cmdRead(cmdRead),
    .cmdBank(cmdBank), .cmdCol(cmdCol), .dqMask(dqMask),
    .strobe(strobe), .selBank(selBank), .selCol(selCol)
  );

  rd_data_path #(
    .BANK_W(BANK_W), .COL_W(COL_W), .DATA_W(DATA_W), .SALT(SALT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .selBank(selBank),
    .selCol(selCol), .dout(dout), .doutValid(doutValid)
  );

endmodule

// File: rtl/sdram_rd_pipe_chk.sv
module sdram_rd_pipe_chk #(
  parameter int DATA_W    = 32,
  parameter int BURST_LEN = 4,
  parameter int MAX_CL    = 3,
  localparam int CL_W     = $clog2(MAX_CL + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic [CL_W-1:0]   casLat,
  input logic              cmdRead,
  input logic              dqMask,
  input logic [DATA_W-1:0] dout,
  input logic              doutValid
);

  int effLat;
  always_comb begin
    if (casLat == '0) effLat = 1;
    else if (int'(casLat) > MAX_CL) effLat = MAX_CL;
    else effLat = int'(casLat);
  end

  logic [3:0] since;
  logic       seen;
  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      since <= '0;
      seen  <= 1'b0;
      age   <= '0;
    end else begin
      if (age != 2'd3) age <= age + 2'd1;
      if (cmdRead) begin
        since <= '0;
        seen  <= 1'b1;
      end else if (since != 4'hF) begin
        since <= since + 4'd1;
      end
    end
  end

  // R8: idle bus carries zero
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    !doutValid |-> dout == '0);

  // R7: mask blanks the word two edges later
  p_mask_blank_r7: assert property (@(posedge clk) disable iff (!rstN)
    dqMask |-> ##3 !doutValid);

  // R1: no word outside the latest read's window
  p_no_stray_r1: assert property (@(posedge clk) disable iff (!rstN)
    doutValid |-> seen && int'(since) <= effLat + BURST_LEN - 1);

  // R5: every unmasked slot of the latest read is filled
  p_burst_full_r5: assert property (@(posedge clk) disable iff (!rstN)
    (seen && age == 2'd3 && int'(since) >= effLat &&
     int'(since) <= effLat + BURST_LEN - 1 && !$past(dqMask, 3))
    |-> doutValid);

endmodule

bind sdram_rd_pipe sdram_rd_pipe_chk #(
  .DATA_W(DATA_W), .BURST_LEN(BURST_LEN), .MAX_CL(MAX_CL)
) u_chk (
  .clk(clk), .rstN(rstN), .casLat(casLat), .cmdRead(cmdRead),
  .dqMask(dqMask), .dout(dout), .doutValid(doutValid)
);

// File: tb/sim_sdram_rd_pipe.sv
module sim_sdram_rd_pipe;

  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  casLat;
  logic        cmdRead;
  logic        cmdBank;
  logic [7:0]  cmdCol;
  logic        dqMask;
  logic [31:0] dout;
  logic        doutValid;

  always #2.5 clk = ~clk;

  sdram_rd_pipe u0 (
    .clk(clk), .rstN(rstN), .casLat(casLat), .cmdRead(cmdRead),
    .cmdBank(cmdBank), .cmdCol(cmdCol), .dqMask(dqMask),
    .dout(dout), .doutValid(doutValid)
  );

  int nChk = 0;
  int nBad = 0;
  int edgeNo = 0;
  bit [31:0] expW [16];
  bit        expV [16];
  bit        expM [16];

  function automatic bit [31:0] wordOf(bit b, bit [7:0] c);
    return {23'd0, b, c} ^ 32'hA5A5_0000;   // R3 formula
  endfunction

  function automatic bit [7:0] colOf(bit [7:0] s, int i);
    bit [1:0] lo;
    lo = s[1:0] + 2'(i);
    return {s[7:2], lo};                     // R2 wrap
  endfunction

  function automatic int latOf(bit [1:0] l);
    return (l == 2'd0) ? 1 : int'(l);        // R1 clamp
  endfunction

  task automatic check(string tag, bit [31:0] aw, bit av, bit [31:0] ew, bit ev);
    nChk++;
    if (aw !== ew || av !== ev) begin
      nBad++;
      $display("FAIL %s edge %0d: dout=%h valid=%b expected dout=%h valid=%b",
               tag, edgeNo, aw, av, ew, ev);
    end
  endtask

  // One clock: update model with inputs sampled at this edge, then compare.
  task automatic tick(string tag);
    int s;
    bit ev;
    bit [31:0] ew;
    string t;
    @(posedge clk);
    edgeNo++;
    if (rstN) begin
      if (cmdRead) begin
        for (int i = 0; i < 4; i++) begin
          s = (edgeNo + latOf(casLat) + i) % 16;
          expW[s] = wordOf(cmdBank, colOf(cmdCol, i));
          expV[s] = 1'b1;
        end
      end
      if (dqMask) expM[(edgeNo + 2) % 16] = 1'b1;
    end
    #1;
    s  = edgeNo % 16;
    ev = rstN && expV[s] && !expM[s];
    ew = ev ? expW[s] : 32'd0;
    if (!rstN) t = "R9";
    else if (expM[s]) t = "R7";
    else if (!ev) t = "R8";
    else t = tag;
    check(t, dout, doutValid, ew, ev);
    expV[s] = 1'b0;
    expM[s] = 1'b0;
    @(negedge clk);
  endtask

  task automatic drive(bit rd, bit b, bit [7:0] c, bit m, string tag);
    cmdRead = rd; cmdBank = b; cmdCol = c; dqMask = m;
    tick(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 8'd0, 1'b0, tag);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) begin expV[i] = 0; expM[i] = 0; expW[i] = 0; end
    rstN = 1'b0; casLat = 2'd2; cmdRead = 0; cmdBank = 0; cmdCol = 0; dqMask = 0;
    @(negedge clk);
    // R9: reset state, even with a command present
    drive(1'b1, 1'b1, 8'h12, 1'b0, "R9");
    idle(3, "R9");
    rstN = 1'b1;
    idle(4, "R8");

    for (int l = 0; l < 4; l++) begin
      casLat = 2'(l);
      idle(8, "R8");
      // R1: single aligned read, latency placement
      drive(1'b1, 1'b0, 8'h04, 1'b0, "R1");
      idle(8, "R1");
      // R2: wrap inside aligned block (6,7,4,5)
      drive(1'b1, 1'b0, 8'h06, 1'b0, "R2");
      idle(8, "R2");
      // R5: seamless pair four edges apart
      drive(1'b1, 1'b1, 8'h10, 1'b0, "R5");
      idle(3, "R5");
      drive(1'b1, 1'b0, 8'h21, 1'b0, "R5");
      idle(8, "R5");
      // R4: interruption, then reads on every edge
      drive(1'b1, 1'b0, 8'h30, 1'b0, "R4");
      idle(1, "R4");
      drive(1'b1, 1'b0, 8'h35, 1'b0, "R4");
      drive(1'b1, 1'b1, 8'h3A, 1'b0, "R4");
      drive(1'b1, 1'b0, 8'h3F, 1'b0, "R4");
      idle(8, "R4");
      // R6: both banks, same column, last column of the array
      drive(1'b1, 1'b1, 8'hFF, 1'b0, "R6");
      idle(3, "R6");
      drive(1'b1, 1'b0, 8'hFF, 1'b0, "R6");
      idle(8, "R6");
      // R7: mask one word mid-burst, burst keeps advancing
      drive(1'b1, 1'b1, 8'h40, 1'b0, "R7");
      drive(1'b0, 1'b0, 8'h00, 1'b1, "R7");
      idle(8, "R7");
      // R7 with R4: mask landing on the handover edge of an interrupted burst
      drive(1'b1, 1'b0, 8'h50, 1'b0, "R4");
      drive(1'b0, 1'b0, 8'h00, 1'b1, "R7");
      drive(1'b1, 1'b1, 8'h55, 1'b1, "R4");
      idle(8, "R4");
    end

    // Random phase per latency (R3 word values under mixed traffic)
    for (int l = 1; l < 4; l++) begin
      casLat = 2'(l);
      idle(8, "R8");
      for (int i = 0; i < 1500; i++) begin
        drive(($urandom % 3) == 0, 1'($urandom), 8'($urandom),
              ($urandom % 8) == 0, "R3");
      end
      idle(10, "R8");
    end
    summary();
  end

endmodule